// File: doc/BRIEF.md
# Counted-Loop Branch Resolver

This block carries out the counter-based loop instructions of a small processor core: count down and branch, count up and branch, or test a register and branch. The branch fires on a zero or nonzero result. A single postbyte names the operation and the register, and it also supplies the sign bit of the branch displacement. The caller presents the postbyte, the displacement byte, the fall-through program counter and the current register values, then pulses `start`. After a fixed three-cycle sequence the block reports the register write-back, whether the branch is taken and the next program counter. The block never touches the condition-code flags and has no port for them.

The register file has two narrow accumulators and four wide registers: a second accumulator pair, two index registers and the stack pointer. A narrow register counts and wraps within its own width. The caller keeps every input stable from the `start` cycle until `done` and commits the write-back itself.

Top module: `loop_branch_unit`

## Requirements
- R1: Postbyte field positions: bits 7..5 are the operation, bits 2..0 are the register, bit 4 is the displacement sign, and bit 3 has no effect. Operation codes: 000 count down and branch on zero, 001 count down and branch on nonzero, 010 test and branch on zero, 011 test and branch on nonzero, 100 count up and branch on zero, 101 count up and branch on nonzero. Register codes: 0 = narrow A, 1 = narrow B, 4 = wide D, 5 = wide X, 6 = wide Y, 7 = stack pointer.
- R2: When `start` is sampled high while idle, `busy` is high in the next two cycles. `done` is a one-cycle pulse in the third cycle after the accepting edge. A `start` sampled while busy has no effect.
- R3: Count-down operations write the register value minus one. They branch when that result is zero (000) or nonzero (001).
- R4: Count-up operations write the register value plus one. They branch when that result is zero (100) or nonzero (101).
- R5: Test operations (010, 011) never assert `wb_en`. They branch on the unchanged register value being zero or nonzero.
- R6: Codes 0 and 1 count and test within 8 bits, wrapping 0x00 to 0xFF and back, and `wb_data` carries zeros above bit 7. The wide registers wrap within 16 bits.
- R7: A taken branch gives `pc_next` = `pc_in` + sign-extend({postbyte[4], offset_byte}) modulo 2^16. A branch not taken gives `pc_next` = `pc_in`.
- R8: Register codes 2 and 3, and operation codes 110 and 111, set `illegal` with `done`. In that case `wb_en` and `taken` stay low and `pc_next` = `pc_in`.
- R9: While `wb_en` is high it coincides with `done`, and `wb_sel` equals postbyte bits 2..0.
- R10: After reset, `busy`, `done`, `wb_en`, `taken` and `illegal` are low and `pc_next` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| postbyte | input | 8 | Operation, register and displacement sign |
| offset_byte | input | 8 | Low bits of the branch displacement |
| pc_in | input | 16 | Fall-through program counter |
| reg_a | input | 8 | Narrow register A |
| reg_b | input | 8 | Narrow register B |
| reg_d | input | 16 | Wide register D |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Result valid pulse |
| wb_en | output | 1 | Write `wb_data` into register `wb_sel` |
| wb_sel | output | 3 | Register code of the write-back |
| wb_data | output | 16 | New register value |
| taken | output | 1 | Branch taken |
| pc_next | output | 16 | Next program counter |
| illegal | output | 1 | Unsupported postbyte |

## Verification
The bench counts narrow registers through their wrap points (0x00 down, 0xFF up). A design that did its arithmetic at 16 bits would write 0xFFFF or 0x0100 and get the zero decision wrong. The extreme displacements −256 and +255 are applied. A design that dropped or misplaced the postbyte sign bit would land on the wrong address. The bench also sends test operations, illegal codes, a set bit 3 and a `start` raised while busy. A design that wrote back on a test, acted on an illegal code, decoded bit 3 or restarted mid-sequence would show a write pulse, branch or result that the requirements forbid.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
   typedef enum logic [1:0] {K_DOWN, K_TEST, K_UP, K_BAD} kind_e;

   typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_RESOLVE} state_e;

   typedef struct packed {
      kind_e      kind;
      logic       on_zero;
      logic       narrow;
      logic       bad_reg;
      logic [2:0] rsel;
   } dec_t;
endpackage

// File: rtl/lbu_decode.sv
module lbu_decode
   import lbu_pkg::*;
(
   input  logic [7:0] pb,
   output dec_t       dec
);
   always_comb begin
      dec.rsel    = pb[2:0];
      dec.narrow  = ~pb[2];
      dec.bad_reg = (pb[2:0] == 3'd2) || (pb[2:0] == 3'd3);
      dec.on_zero = ~pb[5];
      unique case (pb[7:6])
         2'b00:   dec.kind = K_DOWN;
         2'b01:   dec.kind = K_TEST;
         2'b10:   dec.kind = K_UP;
         default: dec.kind = K_BAD;
      endcase
   end
endmodule

// File: rtl/lbu_operand_mux.sv
module lbu_operand_mux #(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16
) (
   input  logic [2:0]          rsel,
   input  logic [NARROW_W-1:0] reg_a,
   input  logic [NARROW_W-1:0] reg_b,
   input  logic [WIDE_W-1:0]   reg_d,
   input  logic [WIDE_W-1:0]   reg_x,
   input  logic [WIDE_W-1:0]   reg_y,
   input  logic [WIDE_W-1:0]   reg_sp,
   output logic [WIDE_W-1:0]   operand
);
   logic [WIDE_W-1:0] ext_a, ext_b;

   generate
      if (WIDE_W == NARROW_W) begin : g_same
         assign ext_a = reg_a;
         assign ext_b = reg_b;
      end else begin : g_extend
         assign ext_a = {{(WIDE_W-NARROW_W){1'b0}}, reg_a};
         assign ext_b = {{(WIDE_W-NARROW_W){1'b0}}, reg_b};
      end
   endgenerate

   always_comb begin
      unique case (rsel)
         3'd0:    operand = ext_a;
         3'd1:    operand = ext_b;
         3'd4:    operand = reg_d;
         3'd5:    operand = reg_x;
         3'd6:    operand = reg_y;
         3'd7:    operand = reg_sp;
         default: operand = '0;
      endcase
   end
endmodule

// File: rtl/lbu_alu.sv
module lbu_alu
   import lbu_pkg::*;
#(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16
) (
   input  kind_e             kind,
   input  logic              narrow,
   input  logic [WIDE_W-1:0] operand,
   output logic [WIDE_W-1:0] result,
   output logic              is_zero
);
   logic [WIDE_W-1:0] raw;

   always_comb begin
      unique case (kind)
         K_DOWN:  raw = operand - WIDE_W'(1);
         K_UP:    raw = operand + WIDE_W'(1);
         default: raw = operand;
      endcase
   end

   generate
      if (WIDE_W == NARROW_W) begin : g_same
         assign result = raw;
      end else begin : g_mask
         assign result = narrow ? {{(WIDE_W-NARROW_W){1'b0}}, raw[NARROW_W-1:0]} : raw;
      end
   endgenerate

   assign is_zero = (result == '0);
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
   import lbu_pkg::*;
#(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16,
   parameter int OFF_W    = 8,
   parameter int PC_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [7:0]          postbyte,
   input  logic [OFF_W-1:0]    offset_byte,
   input  logic [PC_W-1:0]     pc_in,
   input  logic [NARROW_W-1:0] reg_a,
   input  logic [NARROW_W-1:0] reg_b,
   input  logic [WIDE_W-1:0]   reg_d,
   input  logic [WIDE_W-1:0]   reg_x,
   input  logic [WIDE_W-1:0]   reg_y,
   input  logic [WIDE_W-1:0]   reg_sp,
   output logic                busy,
   output logic                done,
   output logic                wb_en,
   output logic [2:0]          wb_sel,
   output logic [WIDE_W-1:0]   wb_data,
   output logic                taken,
   output logic [PC_W-1:0]     pc_next,
   output logic                illegal
);
   localparam int BR_W = OFF_W + 1;

   generate
      if (NARROW_W > WIDE_W) begin : g_chk_width
         $error("NARROW_W must not exceed WIDE_W");
      end
      if (PC_W <= BR_W) begin : g_chk_pc
         $error("PC_W must be wider than the displacement");
      end
   endgenerate

   state_e            state;
   dec_t              in_dec, s1_dec;
   logic [WIDE_W-1:0] in_opnd, s1_opnd, alu_res, s2_res;
   logic              alu_zero, s2_zero;
   logic [BR_W-1:0]   s1_off;
   logic [PC_W-1:0]   s1_pc, disp;
   logic              s1_bad, s1_taken, s1_write;

   lbu_decode u_dec (
      .pb  (postbyte),
      .dec (in_dec)
   );

   lbu_operand_mux #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_mux (
      .rsel    (in_dec.rsel),
      .reg_a   (reg_a),
      .reg_b   (reg_b),
      .reg_d   (reg_d),
      .reg_x   (reg_x),
      .reg_y   (reg_y),
      .reg_sp  (reg_sp),
      .operand (in_opnd)
   );

   lbu_alu #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_alu (
      .kind    (s1_dec.kind),
      .narrow  (s1_dec.narrow),
      .operand (s1_opnd),
      .result  (alu_res),
      .is_zero (alu_zero)
   );

   assign s1_bad   = (s1_dec.kind == K_BAD) || s1_dec.bad_reg;
   assign s1_taken = !s1_bad && (s2_zero == s1_dec.on_zero);
   assign s1_write = !s1_bad && (s1_dec.kind != K_TEST);
   assign disp     = {{(PC_W-BR_W){s1_off[BR_W-1]}}, s1_off};
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         s1_dec  <= '0;
         s1_opnd <= '0;
         s1_off  <= '0;
         s1_pc   <= '0;
         s2_res  <= '0;
         s2_zero <= 1'b0;
         done    <= 1'b0;
         wb_en   <= 1'b0;
         wb_sel  <= '0;
         wb_data <= '0;
         taken   <= 1'b0;
         pc_next <= '0;
         illegal <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               done  <= 1'b0;
               wb_en <= 1'b0;
               if (start) begin
                  s1_dec  <= in_dec;
                  s1_opnd <= in_opnd;
                  s1_off  <= {postbyte[4], offset_byte};
                  s1_pc   <= pc_in;
                  state   <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               s2_res  <= alu_res;
               s2_zero <= alu_zero;
               state   <= ST_RESOLVE;
            end
            ST_RESOLVE: begin
               done    <= 1'b1;
               illegal <= s1_bad;
               wb_en   <= s1_write;
               wb_sel  <= s1_dec.rsel;
               wb_data <= s2_res;
               taken   <= s1_taken;
               pc_next <= s1_taken ? s1_pc + disp : s1_pc;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic wb_en,
   input logic taken,
   input logic illegal
);
   // R2: accepted start leads to two busy cycles then done
   a_r2_three_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy ##1 busy ##1 done);

   // R2: done is a single-cycle pulse
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: no result while the sequence is still running
   a_r2_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R9: write-back only with done
   a_r9_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);

   // R8: illegal postbyte neither writes nor branches
   a_r8_illegal_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (done && illegal) |-> (!wb_en && !taken));
endmodule

bind loop_branch_unit lbu_checker u_lbu_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .wb_en   (wb_en),
   .taken   (taken),
   .illegal (illegal)
);

// File: tb/test_loop_branch_unit.sv
module test_loop_branch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  postbyte = '0;
   logic [7:0]  offset_byte = '0;
   logic [15:0] pc_in = '0;
   logic [7:0]  reg_a = '0, reg_b = '0;
   logic [15:0] reg_d = '0, reg_x = '0, reg_y = '0, reg_sp = '0;
   logic        busy, done, wb_en, taken, illegal;
   logic [2:0]  wb_sel;
   logic [15:0] wb_data, pc_next;

   int vectors = 0;
   int errors  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   loop_branch_unit i_loop_branch_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
      .offset_byte(offset_byte), .pc_in(pc_in), .reg_a(reg_a), .reg_b(reg_b),
      .reg_d(reg_d), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
      .busy(busy), .done(done), .wb_en(wb_en), .wb_sel(wb_sel),
      .wb_data(wb_data), .taken(taken), .pc_next(pc_next), .illegal(illegal)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected results from the requirements
   task automatic model(input logic [7:0] pb, input logic [7:0] off,
                        output logic e_wb, output logic [15:0] e_data,
                        output logic e_tk, output logic [15:0] e_pc, output logic e_ill);
      logic [2:0]  op = pb[7:5];
      logic [2:0]  rs = pb[2:0];
      logic [15:0] v, nv, disp;
      logic        legal;
      legal = (op <= 3'd5) && (rs != 3'd2) && (rs != 3'd3);
      case (rs)
         3'd0: v = {8'h00, reg_a};
         3'd1: v = {8'h00, reg_b};
         3'd4: v = reg_d;
         3'd5: v = reg_x;
         3'd6: v = reg_y;
         default: v = reg_sp;
      endcase
      case (op[2:1])
         2'b00:   nv = v - 16'd1;
         2'b10:   nv = v + 16'd1;
         default: nv = v;
      endcase
      if (!rs[2]) nv = nv & 16'h00FF;
      e_tk   = legal && ((nv == 16'd0) == !op[0]);
      e_wb   = legal && (op[2:1] != 2'b01);
      e_data = nv;
      e_ill  = !legal;
      disp   = {{7{pb[4]}}, pb[4], off};
      e_pc   = e_tk ? pc_in + disp : pc_in;
   endtask

   // Runs one operation and checks its timing and results
   task automatic run_op(input string req, input logic [7:0] pb, input logic [7:0] off);
      logic        e_wb, e_tk, e_ill;
      logic [15:0] e_data, e_pc;
      model(pb, off, e_wb, e_data, e_tk, e_pc, e_ill);
      @(negedge clk);
      postbyte = pb; offset_byte = off; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, " R2 busy"}, busy, 1);
      @(negedge clk);
      check({req, " R2 early"}, done, 0);
      @(negedge clk);
      check({req, " R2 done"}, done, 1);
      check({req, " wb_en"}, wb_en, e_wb);
      if (e_wb) begin
         check({req, " wb_data"}, wb_data, e_data);
         check({req, " R9 wb_sel"}, wb_sel, pb[2:0]);
      end
      check({req, " taken"}, taken, e_tk);
      check({req, " R7 pc_next"}, pc_next, e_pc);
      check({req, " R8 illegal"}, illegal, e_ill);
      @(negedge clk);
      check({req, " R2 pulse"}, done, 0);
   endtask

   task automatic t_reset;
      check("R10 busy", busy, 0);
      check("R10 done", done, 0);
      check("R10 wb_en", wb_en, 0);
      check("R10 taken", taken, 0);
      check("R10 illegal", illegal, 0);
      check("R10 pc_next", pc_next, 0);
   endtask

   task automatic t_count_down;
      pc_in = 16'h0830; reg_x = 16'd5;
      run_op("R3 down-ne X", 8'h35, 8'hFD);
      reg_a = 8'd1;
      run_op("R3 down-eq A", 8'h00, 8'h10);
      reg_a = 8'd0;
      run_op("R6 down A wrap", 8'h00, 8'h10);
      reg_sp = 16'd0;
      run_op("R6 down SP wrap", 8'h27, 8'h04);
   endtask

   task automatic t_count_up;
      reg_b = 8'hFF;
      run_op("R6 up-ne B wrap", 8'hA1, 8'h20);
      run_op("R4 up-eq B wrap", 8'h81, 8'h20);
      reg_d = 16'hFFFF;
      run_op("R4 up-eq D", 8'h94, 8'h00);
      reg_y = 16'h1234;
      run_op("R4 up-ne Y max", 8'hA6, 8'hFF);
   endtask

   task automatic t_test;
      reg_y = 16'h0000;
      run_op("R5 test-eq Y", 8'h46, 8'h08);
      reg_sp = 16'h0000;
      run_op("R5 test-ne SP", 8'h67, 8'h08);
      reg_a = 8'h80;
      run_op("R5 test-ne A", 8'h60, 8'h02);
   endtask

   task automatic t_fields;
      reg_x = 16'd2; pc_in = 16'h0010;
      run_op("R1 bit3 set", 8'h3D, 8'h00);
      run_op("R7 min disp", 8'h30, 8'h00);
      run_op("R8 reg2", 8'h22, 8'h05);
      run_op("R8 reg3", 8'h03, 8'h05);
      run_op("R8 op110", 8'hC5, 8'h05);
      run_op("R8 op111", 8'hE4, 8'h05);
   endtask

   task automatic t_busy_ignore;
      reg_x = 16'd9; pc_in = 16'h4000;
      @(negedge clk);
      postbyte = 8'h25; offset_byte = 8'h40; start = 1'b1;
      @(negedge clk);
      postbyte = 8'hE2; offset_byte = 8'h00;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R2 ignore done", done, 1);
      check("R2 ignore wb", wb_data, 16'd8);
      check("R2 ignore pc", pc_next, 16'h4040);
      check("R2 ignore ill", illegal, 0);
      @(negedge clk);
      check("R2 ignore no rerun", busy, 0);
      @(negedge clk);
      @(negedge clk);
      check("R2 ignore no extra", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count_down();
      t_count_up();
      t_test();
      t_fields();
      t_busy_ignore();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule